// File: doc/BRIEF.md
# Double-Buffered Converter Configuration Register Bank

This block holds the configuration bytes of a single-channel 14-bit data converter behind a byte-wide parallel host bus. A host write lands in a staging copy of each program field. The converter controls are driven only by a second, active copy. The staged values move into the active copy as one set when the host writes the transfer command. Several fields therefore change together on one edge, and the converter never sees a half-updated configuration.

The port configuration byte at address 0x00 is written and read as a mirrored byte. Bit 6 and bit 1 both select least-significant-bit-first shifting. Bit 5 and bit 2 both request a soft reset. Because each function appears at both ends of the byte, a serial front end places it correctly whichever shift order it uses. The port configuration byte is not double-buffered, and its shift-order flag takes effect at once. A soft reset returns both copies to their defaults.

A three-state sequencer, `cfg_xfer_fsm`, orders these events. The states are ST_IDLE (nothing pending), ST_COMMIT (staged values are copied into the active copy on the next edge) and ST_CLEAR (both copies are reset on the next edge). The next state is computed on every cycle in the same way, whatever the current state. A soft-reset request goes to ST_CLEAR. Otherwise a transfer request goes to ST_COMMIT. With no request the sequencer goes to ST_IDLE. A soft-reset request has priority over a transfer request.

Top module: `cfg_shadow_bank`

## Requirements
- R1: After reset, address 0x00 reads 0x18, every program address reads 0x00, every active output is 0, `act_div_ratio` is 1 and `lsb_first` is 0.
- R2: A write to 0x00 sets `lsb_first` to bit 6 OR bit 1 of the written byte, with no delay through the transfer. Address 0x00 reads back {0, L, S, 1, 1, S, L, 0}, where L is `lsb_first` and S is a pending soft reset.
- R3: The program fields are run mode at 0x08 bits [1:0] (00 run, 01 full power-down, 10 standby, 11 digital reset), clock divider at 0x0B bits [2:0], test mode at 0x0D bits [3:0], self-test start at 0x0E bit 0, and offset trim at 0x10 bits [7:0] (two's complement, −128 to +127). A write to any of them is visible on the next read with the unused bits read as 0, and it leaves the active outputs unchanged.
- R4: Writing 1 to bit 0 of 0xFF (write registered on edge k) copies all staged fields to the active outputs on edge k+1. Writing 0xFF with bit 0 clear changes nothing.
- R5: Bit 0 of 0xFF reads 1 between edges k and k+1 of a transfer and reads 0 afterwards. All other bits of 0xFF read 0.
- R6: Writing 1 to bit 5 or bit 2 of 0x00 on edge k sets bits 5 and 2 of the read-back until edge k+1. On edge k+1 every staged field, every active field and `lsb_first` return to their defaults.
- R7: Address 0x01 reads the CHIP_ID parameter. Address 0x02 reads the SPEED_GRADE parameter in bits [6:4] (000, 001, 010, 011 for the four rate grades), with all other bits 0. Writes to both addresses are ignored.
- R8: Any address not named above reads 0x00, and writes to it change no output and no readable value.
- R9: `act_div_ratio` equals the active clock divider field plus one.
- R10: `rd_data` is 0x00 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Combinational read data |
| lsb_first | output | 1 | Shift-order select for the serial front end |
| act_run_mode | output | 2 | Active run mode |
| act_clk_div | output | 3 | Active clock divider field |
| act_div_ratio | output | 4 | Active division ratio (field + 1) |
| act_test_mode | output | 4 | Active output test mode |
| act_bist_en | output | 1 | Active self-test start |
| act_offset | output | 8 | Active offset trim, two's complement |

## Verification
The bench builds the bank with CHIP_ID = 0x5C and SPEED_GRADE = 3'b010 rather than the defaults. Address 0x01 must then read 0x5C and address 0x02 must read 0x20. This shows that both identity bytes come from the parameters and are not fixed constants. With these values the bench also drives all three sequencer states, the one-cycle window of the transfer flag, and both soft-reset bit positions.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;
    localparam int CFG_AW = 8;
    localparam int CFG_DW = 8;
    localparam int RUN_W  = 2;
    localparam int DIV_W  = 3;
    localparam int TST_W  = 4;
    localparam int OFS_W  = 8;
    localparam int RAT_W  = DIV_W + 1;

    localparam logic [CFG_AW-1:0] A_PORT  = 8'h00;
    localparam logic [CFG_AW-1:0] A_IDENT = 8'h01;
    localparam logic [CFG_AW-1:0] A_GRADE = 8'h02;
    localparam logic [CFG_AW-1:0] A_RUN   = 8'h08;
    localparam logic [CFG_AW-1:0] A_DIV   = 8'h0B;
    localparam logic [CFG_AW-1:0] A_TEST  = 8'h0D;
    localparam logic [CFG_AW-1:0] A_BIST  = 8'h0E;
    localparam logic [CFG_AW-1:0] A_OFS   = 8'h10;
    localparam logic [CFG_AW-1:0] A_XFER  = 8'hFF;

    typedef struct packed {
        logic [RUN_W-1:0] run_mode;
        logic [DIV_W-1:0] clk_div;
        logic [TST_W-1:0] test_mode;
        logic             bist_en;
        logic [OFS_W-1:0] offset;
    } cfg_fields_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_CLEAR  = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/cfg_xfer_fsm.sv
module cfg_xfer_fsm
    import cfg_shadow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_req,
    input  logic srst_req,
    output logic commit,
    output logic clear
);
    xfer_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_COMMIT, ST_CLEAR: begin
                if (srst_req)      state_d = ST_CLEAR;
                else if (xfer_req) state_d = ST_COMMIT;
                else               state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        commit = 1'b0;
        clear  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_COMMIT: commit = 1'b1;
            ST_CLEAR:  clear  = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/cfg_stage_regs.sv
module cfg_stage_regs
    import cfg_shadow_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] addr,
    input  logic [CFG_DW-1:0] wdata,
    input  logic              clear,
    output cfg_fields_t       stage,
    output logic              lsb_first
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage     <= '0;
            lsb_first <= 1'b0;
        end else if (clear) begin
            stage     <= '0;
            lsb_first <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                A_PORT: lsb_first       <= wdata[6] | wdata[1];
                A_RUN:  stage.run_mode  <= wdata[RUN_W-1:0];
                A_DIV:  stage.clk_div   <= wdata[DIV_W-1:0];
                A_TEST: stage.test_mode <= wdata[TST_W-1:0];
                A_BIST: stage.bist_en   <= wdata[0];
                A_OFS:  stage.offset    <= wdata[OFS_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_active_regs.sv
module cfg_active_regs
    import cfg_shadow_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        commit,
    input  logic        clear,
    input  cfg_fields_t stage,
    output cfg_fields_t act
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      act <= '0;
        else if (clear)  act <= '0;
        else if (commit) act <= stage;
    end
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
    import cfg_shadow_pkg::*;
#(
    parameter logic [7:0] CHIP_ID     = 8'hA5,
    parameter logic [2:0] SPEED_GRADE = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_AW-1:0] addr,
    input  logic              wr_en,
    input  logic [CFG_DW-1:0] wdata,
    input  logic              rd_en,
    output logic [CFG_DW-1:0] rd_data,
    output logic              lsb_first,
    output logic [RUN_W-1:0]  act_run_mode,
    output logic [DIV_W-1:0]  act_clk_div,
    output logic [RAT_W-1:0]  act_div_ratio,
    output logic [TST_W-1:0]  act_test_mode,
    output logic              act_bist_en,
    output logic [OFS_W-1:0]  act_offset
);
    localparam int NIB = CFG_DW / 2;

    cfg_fields_t stage_q;
    cfg_fields_t act_q;
    logic        commit;
    logic        clear;
    logic        xfer_req;
    logic        srst_req;
    logic [NIB-1:0]    lo_nib;
    logic [CFG_DW-1:0] port_byte;
    logic [CFG_DW-1:0] rd_mux;

    assign xfer_req = wr_en && (addr == A_XFER) && wdata[0];
    assign srst_req = wr_en && (addr == A_PORT) && (wdata[5] | wdata[2]);

    cfg_xfer_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer_req (xfer_req),
        .srst_req (srst_req),
        .commit   (commit),
        .clear    (clear)
    );

    cfg_stage_regs u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .clear     (clear),
        .stage     (stage_q),
        .lsb_first (lsb_first)
    );

    cfg_active_regs u_active (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .clear  (clear),
        .stage  (stage_q),
        .act    (act_q)
    );

    // low nibble of the port byte: fixed 1, soft reset, shift order, fixed 0
    assign lo_nib = {1'b1, clear, lsb_first, 1'b0};

    // the high nibble is the low nibble in reversed bit order
    for (genvar gi = 0; gi < NIB; gi++) begin : g_mirror
        assign port_byte[gi]          = lo_nib[gi];
        assign port_byte[CFG_DW-1-gi] = lo_nib[gi];
    end

    always_comb begin
        rd_mux = '0;
        case (addr)
            A_PORT:  rd_mux = port_byte;
            A_IDENT: rd_mux = CHIP_ID;
            A_GRADE: rd_mux = {1'b0, SPEED_GRADE, 4'b0000};
            A_RUN:   rd_mux[RUN_W-1:0] = stage_q.run_mode;
            A_DIV:   rd_mux[DIV_W-1:0] = stage_q.clk_div;
            A_TEST:  rd_mux[TST_W-1:0] = stage_q.test_mode;
            A_BIST:  rd_mux[0]         = stage_q.bist_en;
            A_OFS:   rd_mux[OFS_W-1:0] = stage_q.offset;
            A_XFER:  rd_mux[0]         = commit;
            default: rd_mux = '0;
        endcase
    end

    assign rd_data       = rd_en ? rd_mux : '0;
    assign act_run_mode  = act_q.run_mode;
    assign act_clk_div   = act_q.clk_div;
    assign act_div_ratio = {1'b0, act_q.clk_div} + RAT_W'(1);
    assign act_test_mode = act_q.test_mode;
    assign act_bist_en   = act_q.bist_en;
    assign act_offset    = act_q.offset;
endmodule

// File: rtl/cfg_shadow_bank_chk.sv
module cfg_shadow_bank_chk
    import cfg_shadow_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        commit,
    input logic        clear,
    input logic        xfer_req,
    input logic        lsb_first,
    input cfg_fields_t stage,
    input cfg_fields_t act
);
    // R4: the active copy moves only through the commit or clear states
    assert_hold_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !clear) |=> $stable(act));

    // R4: a commit copies the staged set as it stood before the edge
    assert_commit_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (act == $past(stage)));

    // R5: the transfer flag lasts one cycle unless a new transfer arrives
    assert_xfer_selfclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !xfer_req) |=> !commit);

    // R6: a clear returns both copies and the shift order to defaults
    assert_clear_defaults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (act == '0 && stage == '0 && !lsb_first));

    // R6: commit and clear are never active together
    assert_state_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit, clear}));
endmodule

bind cfg_shadow_bank cfg_shadow_bank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .clear     (clear),
    .xfer_req  (xfer_req),
    .lsb_first (lsb_first),
    .stage     (stage_q),
    .act       (act_q)
);

// File: tb/cfg_shadow_bank_bench.sv
`timescale 1ns/1ps
module cfg_shadow_bank_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       lsb_first;
    logic [1:0] act_run_mode;
    logic [2:0] act_clk_div;
    logic [3:0] act_div_ratio;
    logic [3:0] act_test_mode;
    logic       act_bist_en;
    logic [7:0] act_offset;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cfg_shadow_bank #(.CHIP_ID(8'h5C), .SPEED_GRADE(3'b010)) u_cfg_shadow_bank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rd_data(rd_data), .lsb_first(lsb_first),
        .act_run_mode(act_run_mode), .act_clk_div(act_clk_div),
        .act_div_ratio(act_div_ratio), .act_test_mode(act_test_mode),
        .act_bist_en(act_bist_en), .act_offset(act_offset)
    );

    // {address, write data, expected read-back}
    localparam logic [23:0] VEC [16] = '{
        {8'h08, 8'h03, 8'h03}, {8'h08, 8'hFE, 8'h02},
        {8'h0B, 8'hFF, 8'h07}, {8'h0D, 8'h0C, 8'h0C},
        {8'h0D, 8'hF5, 8'h05}, {8'h0E, 8'h01, 8'h01},
        {8'h0E, 8'hFE, 8'h00}, {8'h10, 8'h80, 8'h80},
        {8'h10, 8'h7F, 8'h7F}, {8'h01, 8'h00, 8'h5C},
        {8'h02, 8'hFF, 8'h20}, {8'h20, 8'h55, 8'h00},
        {8'h0A, 8'hAA, 8'h00}, {8'h00, 8'h02, 8'h5A},
        {8'h00, 8'h40, 8'h5A}, {8'h00, 8'h00, 8'h18}
    };

    function automatic string tag_of(logic [7:0] a);
        case (a)
            8'h00:        return "R2";
            8'h01, 8'h02: return "R7";
            8'h08, 8'h0B, 8'h0D, 8'h0E, 8'h10: return "R3";
            default:      return "R8";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic do_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [7:0] exp);
        addr = a; rd_en = 1'b1;
        #1;
        chk(tag, 32'(rd_data), 32'(exp));
        rd_en = 1'b0;
    endtask

    task automatic chk_act(string tag, logic [1:0] rm, logic [2:0] cd,
                           logic [3:0] tm, logic be, logic [7:0] of);
        chk(tag, 32'(act_run_mode), 32'(rm));
        chk(tag, 32'(act_clk_div), 32'(cd));
        chk("R9", 32'(act_div_ratio), 32'(cd) + 32'd1);
        chk(tag, 32'(act_test_mode), 32'(tm));
        chk(tag, 32'(act_bist_en), 32'(be));
        chk(tag, 32'(act_offset), 32'(of));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1", 8'h00, 8'h18);
        rd_chk("R1", 8'h08, 8'h00);
        rd_chk("R1", 8'h10, 8'h00);
        chk("R1", 32'(lsb_first), 32'd0);
        chk_act("R1", 2'd0, 3'd0, 4'd0, 1'b0, 8'h00);

        // table walk: write then read back
        for (int i = 0; i < 16; i++) begin
            do_write(VEC[i][23:16], VEC[i][15:8]);
            rd_chk(tag_of(VEC[i][23:16]), VEC[i][23:16], VEC[i][7:0]);
        end
        // R3 staged writes left the active copy untouched
        chk_act("R3", 2'd0, 3'd0, 4'd0, 1'b0, 8'h00);

        // R2 shift-order flag acts at once
        do_write(8'h00, 8'h40);
        chk("R2", 32'(lsb_first), 32'd1);
        do_write(8'h00, 8'h02);
        chk("R2", 32'(lsb_first), 32'd1);
        do_write(8'h00, 8'h00);
        chk("R2", 32'(lsb_first), 32'd0);

        // R4 transfer register write with bit 0 clear
        do_write(8'hFF, 8'hFE);
        rd_chk("R5", 8'hFF, 8'h00);
        @(negedge clk);
        chk_act("R4", 2'd0, 3'd0, 4'd0, 1'b0, 8'h00);

        // R4/R5 transfer: flag for one cycle, outputs on the next edge
        do_write(8'hFF, 8'h01);
        rd_chk("R5", 8'hFF, 8'h01);
        chk("R4", 32'(act_run_mode), 32'd0);
        @(negedge clk);
        rd_chk("R5", 8'hFF, 8'h00);
        chk_act("R4", 2'd2, 3'd7, 4'd5, 1'b0, 8'h7F);

        // R4 second transfer with several fields changed
        do_write(8'h0E, 8'h01);
        do_write(8'h0B, 8'h01);
        chk("R4", 32'(act_div_ratio), 32'd8);
        do_write(8'hFF, 8'hFF);
        @(negedge clk);
        chk_act("R4", 2'd2, 3'd1, 4'd5, 1'b1, 8'h7F);

        // R6 soft reset through bit 2
        do_write(8'h00, 8'h04);
        rd_chk("R6", 8'h00, 8'h3C);
        @(negedge clk);
        rd_chk("R6", 8'h00, 8'h18);
        rd_chk("R6", 8'h08, 8'h00);
        rd_chk("R6", 8'h0B, 8'h00);
        chk_act("R6", 2'd0, 3'd0, 4'd0, 1'b0, 8'h00);

        // R6 soft reset through bit 5 with shift order set
        do_write(8'h10, 8'h33);
        do_write(8'hFF, 8'h01);
        @(negedge clk);
        chk("R3", 32'(act_offset), 32'h33);
        do_write(8'h00, 8'h62);
        rd_chk("R6", 8'h00, 8'h7E);
        chk("R2", 32'(lsb_first), 32'd1);
        @(negedge clk);
        rd_chk("R6", 8'h00, 8'h18);
        rd_chk("R6", 8'h10, 8'h00);
        chk("R6", 32'(act_offset), 32'h00);
        chk("R6", 32'(lsb_first), 32'd0);

        // R8 unmapped write leaves outputs and staged values unchanged
        do_write(8'h0C, 8'hFF);
        rd_chk("R8", 8'h0C, 8'h00);
        rd_chk("R8", 8'h0B, 8'h00);
        chk_act("R8", 2'd0, 3'd0, 4'd0, 1'b0, 8'h00);

        // R10 no read strobe, zero data
        addr = 8'h01; rd_en = 1'b0;
        #1;
        chk("R10", 32'(rd_data), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule